// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block moves operand words between memory and a numeric coprocessor. The core first loads an operand address, a word count and a transfer direction. The coprocessor then raises an asynchronous request. For each word, the block issues two bus operations, one after the other, to a bus cycle sequencer. The first operation reads the source. The second writes the data it just read to the destination. The coprocessor's end of every transfer is a single fixed I/O port at address 0x00FA.

Which operation comes first depends on the direction. For a coprocessor-to-memory word, the block reads the port and then writes memory. For a memory-to-coprocessor word, it reads memory and then writes the port. The acknowledge to the coprocessor is high only while the first operation of a word is on the bus. This gives the coprocessor a point at which to withdraw its request before the block starts a further word. After each word, the address steps by two and the count drops by one. When the count reaches zero, the block stays idle.

Top module: `copx_xfer_seq`

## Requirements
- R1: After reset, `bus_req`, `cop_ack` and `busy` are all 0.
- R2: A word transfer starts only when the synchronised request is high and the remaining count is non-zero. With a count of 0, a held request produces no bus operation.
- R3: With `cfg_dir` = 0 (memory to coprocessor), each word is first a memory read (`bus_is_io`=0, `bus_write`=0) at the operand address. It is then an I/O write (`bus_is_io`=1, `bus_write`=1) to address 0x00FA.
- R4: With `cfg_dir` = 1 (coprocessor to memory), each word is first an I/O read from 0x00FA. It is then a memory write at the operand address.
- R5: `cop_ack` is 1 during the whole first operation of every word and 0 at all other times.
- R6: After each completed word, the operand address advances by 2 and the count decrements by 1. Exactly `cfg_count` words are moved, after which the block stays idle even if the request is still high.
- R7: An operation keeps `bus_req`, `bus_addr`, `bus_is_io` and `bus_write` unchanged until `bus_done` is sampled high. Each operation completes only on `bus_done`.
- R8: A `cfg_load` pulse while a transfer is in progress is ignored. The address, count and direction already in use are kept.
- R9: The data returned by the first operation (`bus_rdata` at its `bus_done`) is driven on `bus_wdata` during the second operation.
- R10: If the request drops within one cycle after the first operation of a word completes, no further word starts. The remaining count is kept, and the transfer resumes when the request is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load operand address, count and direction (taken only while idle) |
| cfg_addr | input | 24 | Operand start address |
| cfg_count | input | 8 | Number of words to move |
| cfg_dir | input | 1 | 0 = memory to coprocessor, 1 = coprocessor to memory |
| cop_req | input | 1 | Asynchronous transfer request from the coprocessor |
| cop_ack | output | 1 | High during the first operation of each word |
| bus_req | output | 1 | Bus operation requested |
| bus_is_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 24 | Operation address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_done` |
| bus_done | input | 1 | Completion of the current operation |
| busy | output | 1 | A word transfer is in progress |

## Verification
The hardest case to reach is the request-withdrawal window. The request must fall late enough that the current word has started, yet early enough that the two synchroniser stages clear before the second operation finishes.

The bench handles this in two steps. It watches its own bus model and drops the request on the exact cycle the first operation is acknowledged. It then completes the second operation with the smallest wait the model allows, or more. It also checks that the leftover count resumes correctly.

The bus model inserts random wait states between zero and three cycles. This varies how long operations are held in both directions.

// File: rtl/copx_pkg.sv
package copx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_st_e;

  // direction code as loaded by the core
  localparam logic DIR_COP_TO_MEM = 1'b1;

  // operand pointer step per word (one 16-bit word = 2 bytes)
  function automatic logic [31:0] step_addr(input logic [31:0] a);
    return a + 32'd2;
  endfunction

  // first operation touches I/O when the coprocessor is the source
  function automatic logic op_in_io(input logic dir, input logic second);
    return second ? ~dir : dir;
  endfunction

endpackage

// File: rtl/copx_sync2.sv
module copx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/copx_opnd_regs.sv
module copx_opnd_regs
  import copx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              load_dir,
  input  logic              adv,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_dir,
  output logic              cnt_nz
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_addr <= '0;
      cnt_q   <= '0;
      op_dir  <= 1'b0;
    end else if (load_en) begin
      op_addr <= load_addr;
      cnt_q   <= load_cnt;
      op_dir  <= load_dir;
    end else if (adv) begin
      op_addr <= ADDR_W'(step_addr(32'(op_addr)));
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign cnt_nz = |cnt_q;
endmodule

// File: rtl/copx_ctl.sv
module copx_ctl
  import copx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h00FA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              cnt_nz,
  input  logic              op_dir,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              bus_is_io,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              cop_ack,
  output logic              seq_start,
  output logic              word_done,
  output logic              idle
);
  seq_st_e           state_q, state_d;
  logic [DATA_W-1:0] hold_q;
  logic              in_first, in_second;

  assign in_first  = (state_q == ST_FIRST);
  assign in_second = (state_q == ST_SECOND);
  assign idle      = (state_q == ST_IDLE);
  assign seq_start = idle && req_s && cnt_nz;
  assign word_done = in_second && bus_done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (seq_start) state_d = ST_FIRST;
      ST_FIRST:  if (bus_done)  state_d = ST_SECOND;
      ST_SECOND: if (bus_done)  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (in_first && bus_done) hold_q <= bus_rdata;
    end
  end

  assign bus_req   = !idle;
  assign bus_write = in_second;
  assign bus_is_io = bus_req && op_in_io(op_dir, in_second);
  assign bus_addr  = bus_is_io ? PORT_ADDR : op_addr;
  assign bus_wdata = hold_q;
  assign cop_ack   = in_first;
endmodule

// File: rtl/copx_xfer_seq.sv
module copx_xfer_seq
  import copx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h00FA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_dir,
  input  logic              cop_req,
  output logic              cop_ack,
  output logic              bus_req,
  output logic              bus_is_io,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  output logic              busy
);
  logic              req_s;
  logic              cnt_nz;
  logic              op_dir;
  logic [ADDR_W-1:0] op_addr;
  logic              seq_start;
  logic              word_done;
  logic              idle;
  logic              load_take;

  assign load_take = cfg_load && idle;

  copx_sync2 #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cop_req),
    .q_sync  (req_s)
  );

  copx_opnd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_opnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_take),
    .load_addr (cfg_addr),
    .load_cnt  (cfg_count),
    .load_dir  (cfg_dir),
    .adv       (word_done),
    .op_addr   (op_addr),
    .op_dir    (op_dir),
    .cnt_nz    (cnt_nz)
  );

  copx_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .cnt_nz    (cnt_nz),
    .op_dir    (op_dir),
    .op_addr   (op_addr),
    .bus_done  (bus_done),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_is_io (bus_is_io),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cop_ack   (cop_ack),
    .seq_start (seq_start),
    .word_done (word_done),
    .idle      (idle)
  );

  assign busy = !idle;
endmodule

// File: rtl/copx_xfer_seq_chk.sv
module copx_xfer_seq_chk #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h00FA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              cop_ack,
  input logic              bus_req,
  input logic              bus_is_io,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_done,
  input logic              seq_start,
  input logic              word_done,
  input logic              cnt_nz,
  input logic [ADDR_W-1:0] op_addr
);
  // R5: a new bus request always opens with the acknowledge high
  a_r5_ack_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> cop_ack);

  // R5: acknowledge only with a read on the bus
  a_r5_ack_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    cop_ack |-> (bus_req && !bus_write));

  // R7: an operation holds until it is acknowledged
  a_r7_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) &&
                                $stable(bus_write) && $stable(bus_is_io)));

  // R3, R4: every I/O operation targets the coprocessor port
  a_r3_r4_io_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_is_io) |-> (bus_addr == PORT_ADDR));

  // R2: no start without words left
  a_r2_start_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> cnt_nz);

  // R6: after a word the block drops back to idle for at least one cycle
  a_r6_word_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !bus_req);

  // R8: a load while busy leaves the pointer alone
  a_r8_load_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && bus_req && !word_done) |=> $stable(op_addr));
endmodule

bind copx_xfer_seq copx_xfer_seq_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .cop_ack   (cop_ack),
  .bus_req   (bus_req),
  .bus_is_io (bus_is_io),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_done  (bus_done),
  .seq_start (seq_start),
  .word_done (word_done),
  .cnt_nz    (cnt_nz),
  .op_addr   (op_addr)
);

// File: tb/copx_xfer_seq_test.sv
module copx_xfer_seq_test;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam logic [AW-1:0] PORT = 24'h0000FA;
  localparam int LOGN = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_dir = 1'b0;
  logic          cop_req = 1'b0;
  logic          cop_ack, bus_req, bus_is_io, bus_write, busy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_done = 1'b0;

  int total = 0;
  int bad = 0;

  // operation log filled by the bus model
  int            nops = 0;
  logic          l_io   [LOGN];
  logic          l_wr   [LOGN];
  logic          l_ack  [LOGN];
  logic [AW-1:0] l_addr [LOGN];
  logic [DW-1:0] l_wd   [LOGN];
  logic [DW-1:0] l_rd   [LOGN];
  int            hold_bad = 0;

  always #5 clk = ~clk;

  copx_xfer_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_dir(cfg_dir), .cop_req(cop_req),
    .cop_ack(cop_ack), .bus_req(bus_req), .bus_is_io(bus_is_io),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural bus sequencer with 0..3 random wait states
  initial begin
    int wcnt;
    logic in_op;
    logic [AW-1:0] last_addr;
    wcnt = 0;
    in_op = 1'b0;
    last_addr = '0;
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      if (bus_req) begin
        if (in_op && bus_addr != last_addr) hold_bad++;
        last_addr = bus_addr;
        in_op = 1'b1;
        if (wcnt == 0) begin
          if (nops < LOGN) begin
            l_io[nops]   = bus_is_io;
            l_wr[nops]   = bus_write;
            l_ack[nops]  = cop_ack;
            l_addr[nops] = bus_addr;
            l_wd[nops]   = bus_wdata;
            l_rd[nops]   = 16'h3C5A ^ DW'(nops * 16'h1111);
            bus_rdata    = l_rd[nops];
          end
          nops++;
          bus_done = 1'b1;
          in_op = 1'b0;
          wcnt = int'($urandom % 4);
        end else begin
          wcnt--;
        end
      end else if (cop_ack) begin
        hold_bad++;
      end
    end
  end

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary_and_end();
  end

  task automatic load_cfg(input logic [AW-1:0] a, input logic [CW-1:0] n, input logic d);
    @(negedge clk);
    cfg_addr = a; cfg_count = n; cfg_dir = d; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // checks one word made of log entries i and i+1
  task automatic check_word(input int i, input logic [AW-1:0] maddr, input logic d);
    if (d == 1'b0) begin
      chk(l_io[i] == 1'b0 && l_wr[i] == 1'b0, "R3 first op mem read", {l_io[i], l_wr[i]}, 0);
      chk(l_addr[i] == maddr, "R3/R6 first op address", l_addr[i], maddr);
      chk(l_io[i+1] == 1'b1 && l_wr[i+1] == 1'b1, "R3 second op io write", {l_io[i+1], l_wr[i+1]}, 3);
      chk(l_addr[i+1] == PORT, "R3 second op port", l_addr[i+1], PORT);
    end else begin
      chk(l_io[i] == 1'b1 && l_wr[i] == 1'b0, "R4 first op io read", {l_io[i], l_wr[i]}, 2);
      chk(l_addr[i] == PORT, "R4 first op port", l_addr[i], PORT);
      chk(l_io[i+1] == 1'b0 && l_wr[i+1] == 1'b1, "R4 second op mem write", {l_io[i+1], l_wr[i+1]}, 1);
      chk(l_addr[i+1] == maddr, "R4/R6 second op address", l_addr[i+1], maddr);
    end
    chk(l_ack[i] == 1'b1, "R5 ack in first op", l_ack[i], 1);
    chk(l_ack[i+1] == 1'b0, "R5 no ack in second op", l_ack[i+1], 0);
    chk(l_wd[i+1] == l_rd[i], "R9 data carried", l_wd[i+1], l_rd[i]);
  endtask

  task automatic t_reset();
    chk(bus_req == 1'b0, "R1 bus_req after reset", bus_req, 0);
    chk(cop_ack == 1'b0, "R1 cop_ack after reset", cop_ack, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_zero_count();
    int s;
    s = nops;
    load_cfg(24'h004000, 8'd0, 1'b0);
    cop_req = 1'b1;
    idle_wait(20);
    chk(nops == s, "R2 no op with zero count", nops - s, 0);
    chk(busy == 1'b0, "R2 stays idle", busy, 0);
    cop_req = 1'b0;
    idle_wait(5);
  endtask

  task automatic t_run(input logic [AW-1:0] base, input int n, input logic d);
    int s;
    s = nops;
    load_cfg(base, CW'(n), d);
    cop_req = 1'b1;
    wait (nops == s + 2 * n);
    idle_wait(25);
    chk(nops == s + 2 * n, "R6 exact word count", nops - s, 2 * n);
    chk(busy == 1'b0, "R6 idle at count zero", busy, 0);
    for (int w = 0; w < n; w++) check_word(s + 2 * w, base + AW'(2 * w), d);
    cop_req = 1'b0;
    idle_wait(5);
  endtask

  task automatic t_load_busy();
    int s;
    s = nops;
    load_cfg(24'h002000, 8'd2, 1'b0);
    cop_req = 1'b1;
    wait (nops == s + 1);
    cfg_addr = 24'h007700; cfg_count = 8'd9; cfg_dir = 1'b1; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wait (nops == s + 4);
    idle_wait(25);
    chk(nops == s + 4, "R8 count kept after busy load", nops - s, 4);
    check_word(s, 24'h002000, 1'b0);
    check_word(s + 2, 24'h002002, 1'b0);
    cop_req = 1'b0;
    idle_wait(5);
  endtask

  task automatic t_withdraw();
    int s;
    s = nops;
    load_cfg(24'h00A100, 8'd3, 1'b1);
    cop_req = 1'b1;
    wait (nops == s + 1);
    cop_req = 1'b0;
    idle_wait(25);
    chk(nops == s + 2, "R10 single word on early withdraw", nops - s, 2);
    chk(busy == 1'b0, "R10 idle after withdraw", busy, 0);
    cop_req = 1'b1;
    wait (nops == s + 6);
    idle_wait(25);
    chk(nops == s + 6, "R10 remaining words resumed", nops - s, 6);
    for (int w = 0; w < 3; w++) check_word(s + 2 * w, 24'h00A100 + AW'(2 * w), 1'b1);
    cop_req = 1'b0;
    idle_wait(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle_wait(2);
    t_reset();
    t_zero_count();
    t_run(24'h001000, 3, 1'b0);
    t_run(24'h0ABCD0, 4, 1'b1);
    t_run(24'hFFFFFC, 1, 1'b0);
    t_load_busy();
    t_withdraw();
    chk(hold_bad == 0, "R7 operations held until done", hold_bad, 0);
    summary_and_end();
  end
endmodule